// File: doc/BRIEF.md
# Shared Edge Interrupt Distributor for Three Processors

One external line is shared by several processors, three by default, and each of them has to be interrupted by it. The block brings the line through a two-stage synchronizer and looks for rising edges. It latches each accepted edge into a separate capture flag for every processor. Each processor has a small register window of its own, with four word offsets. Through it the processor reads the line, sets its interrupt enable, clears its own capture flag and clears its own overrun flag. A clear from one processor affects only that processor's pending request.

A two-state machine controls when edges are accepted. In `ARMED`, a detected rising edge loads every capture flag; the transition is `ARMED -> WAIT_ACK` on the edge. In `WAIT_ACK`, the detector does not capture. It leaves for `ARMED` (transition `WAIT_ACK -> ARMED`) once every processor has acknowledged. A processor has acknowledged when its capture flag is clear or when its interrupt enable is off. If an edge arrives during `WAIT_ACK`, the machine stays in `WAIT_ACK` and sets a sticky overrun flag on every port (self-loop `WAIT_ACK -> WAIT_ACK`, overrun). `ARMED` with no edge holds `ARMED`.

Top module: `edge_irq_dist`

## Requirements
- R1: After reset, every irq output is 0 and every port reads 0 at offsets 1, 2 and 3. The machine is armed, so the first rising edge is captured.
- R2: A rising edge on the input sets the capture flag of every port. irq follows three clock edges after the input rises. A falling edge or a steady level captures nothing. The capture flag is bit 0 at offset 2.
- R3: irq of a port is high exactly when its capture flag and its enable are both set. The enable is bit 0 at offset 1 and can be read back. A disabled port still captures, as seen at offset 2.
- R4: A write of any value to offset 2 clears the capture flag of the writing port only. The other ports keep their pending requests.
- R5: While any enabled port still holds its capture flag, no new edge is captured. A port whose enable is 0 counts as acknowledged and cannot block the re-arm.
- R6: A rising edge that arrives while re-arm is pending sets the overrun flag of every port and leaves the capture flags unchanged. The overrun flag is bit 0 at offset 3.
- R7: Writing to offset 3 with bit 0 set clears the overrun flag of the writing port only. A write with bit 0 clear does nothing.
- R8: Offset 0 returns the synchronized input level in bit 0. Every unused read bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Shared asynchronous event line |
| reg_wr | input | N_CPU | Write strobe, one per processor |
| reg_addr | input | 2*N_CPU | Word offset, 2 bits per processor |
| reg_wdata | input | DATA_W*N_CPU | Write data per processor |
| reg_rdata | output | DATA_W*N_CPU | Read data per processor, combinational from address |
| irq | output | N_CPU | Interrupt request per processor |

## Verification
The key corner case is partial acknowledgement. After one processor clears its flag, the others must still hold theirs. A design with one shared capture flag would drop every request. A second edge must not re-raise the cleared processor's request before the rest have cleared. A design that re-arms on any clear would fire it again and would miss the overrun. A disabled processor that holds a stale capture must not stall the re-arm; a design that ignores the enable would stop taking edges. The bench also checks that a falling edge and a write of 0 to the overrun register change nothing.

// File: rtl/edge_irq_dist_pkg.sv
package edge_irq_dist_pkg;
    typedef enum logic {
        ARMED    = 1'b0,
        WAIT_ACK = 1'b1
    } dist_state_t;

    localparam int REG_AW = 2;
    localparam logic [REG_AW-1:0] OFF_LEVEL  = 2'd0;
    localparam logic [REG_AW-1:0] OFF_ENABLE = 2'd1;
    localparam logic [REG_AW-1:0] OFF_CAPT   = 2'd2;
    localparam logic [REG_AW-1:0] OFF_OVRN   = 2'd3;
endpackage

// File: rtl/edge_sync_detect.sv
module edge_sync_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/cpu_irq_port.sv
module cpu_irq_port
    import edge_irq_dist_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level,
    input  logic              capture_evt,
    input  logic              overrun_evt,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              cap,
    output logic              en,
    output logic              ovr,
    output logic              acked,
    output logic              irq
);
    logic clr_cap, clr_ovr, wr_en;

    assign wr_en   = wr && (addr == OFF_ENABLE);
    assign clr_cap = wr && (addr == OFF_CAPT);
    assign clr_ovr = wr && (addr == OFF_OVRN) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap <= 1'b0;
            en  <= 1'b0;
            ovr <= 1'b0;
        end else begin
            cap <= capture_evt | (cap & ~clr_cap);
            ovr <= overrun_evt | (ovr & ~clr_ovr);
            if (wr_en) en <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFF_LEVEL:  rdata[0] = level;
            OFF_ENABLE: rdata[0] = en;
            OFF_CAPT:   rdata[0] = cap;
            OFF_OVRN:   rdata[0] = ovr;
        endcase
    end

    assign acked = ~cap | ~en;
    assign irq   = cap & en;
endmodule

// File: rtl/edge_irq_dist.sv
module edge_irq_dist
    import edge_irq_dist_pkg::*;
#(
    parameter int N_CPU  = 3,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      line_in,
    input  logic [N_CPU-1:0]          reg_wr,
    input  logic [REG_AW*N_CPU-1:0]   reg_addr,
    input  logic [DATA_W*N_CPU-1:0]   reg_wdata,
    output logic [DATA_W*N_CPU-1:0]   reg_rdata,
    output logic [N_CPU-1:0]          irq
);
    dist_state_t      state, state_nx;
    logic             level, rise;
    logic             capture_evt, overrun_evt, all_acked;
    logic [N_CPU-1:0] cap_flags, en_flags, ovr_flags, acked;

    edge_sync_detect #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (line_in),
        .level    (level),
        .rise     (rise)
    );

    for (genvar i = 0; i < N_CPU; i++) begin : g_port
        cpu_irq_port #(.DATA_W(DATA_W)) u_port (
            .clk         (clk),
            .rst_n       (rst_n),
            .level       (level),
            .capture_evt (capture_evt),
            .overrun_evt (overrun_evt),
            .wr          (reg_wr[i]),
            .addr        (reg_addr[i*REG_AW +: REG_AW]),
            .wdata       (reg_wdata[i*DATA_W +: DATA_W]),
            .rdata       (reg_rdata[i*DATA_W +: DATA_W]),
            .cap         (cap_flags[i]),
            .en          (en_flags[i]),
            .ovr         (ovr_flags[i]),
            .acked       (acked[i]),
            .irq         (irq[i])
        );
    end

    assign all_acked = &acked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ARMED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ARMED:    if (rise) state_nx = WAIT_ACK;
            WAIT_ACK: if (all_acked && !rise) state_nx = ARMED;
        endcase
    end

    always_comb begin
        capture_evt = 1'b0;
        overrun_evt = 1'b0;
        unique case (state)
            ARMED:    capture_evt = rise;
            WAIT_ACK: overrun_evt = rise;
        endcase
    end
endmodule

// File: rtl/edge_irq_dist_chk.sv
module edge_irq_dist_chk
    import edge_irq_dist_pkg::*;
#(
    parameter int N_CPU = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input dist_state_t             state,
    input logic                    capture_evt,
    input logic                    overrun_evt,
    input logic                    all_acked,
    input logic [N_CPU-1:0]        reg_wr,
    input logic [REG_AW*N_CPU-1:0] reg_addr,
    input logic [N_CPU-1:0]        cap_flags,
    input logic [N_CPU-1:0]        en_flags,
    input logic [N_CPU-1:0]        ovr_flags,
    input logic [N_CPU-1:0]        irq
);
    a_r2_capture_all: assert property (@(posedge clk) disable iff (!rst_n)
        capture_evt |=> (&cap_flags) && state == WAIT_ACK);

    a_r5_hold_until_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WAIT_ACK && !all_acked) |=> state == WAIT_ACK);

    a_r6_overrun_all: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_evt |=> (&ovr_flags) && $stable(cap_flags));

    for (genvar i = 0; i < N_CPU; i++) begin : g_chk
        a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !en_flags[i] |-> !irq[i]);

        a_r4_clear_own: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr[i] && reg_addr[i*REG_AW +: REG_AW] == OFF_CAPT && !capture_evt)
            |=> !cap_flags[i]);

        a_r4_keep_pending: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_flags[i] && !(reg_wr[i] && reg_addr[i*REG_AW +: REG_AW] == OFF_CAPT))
            |=> cap_flags[i]);
    end
endmodule

bind edge_irq_dist edge_irq_dist_chk #(.N_CPU(N_CPU)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .capture_evt (capture_evt),
    .overrun_evt (overrun_evt),
    .all_acked   (all_acked),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .cap_flags   (cap_flags),
    .en_flags    (en_flags),
    .ovr_flags   (ovr_flags),
    .irq         (irq)
);

// File: tb/edge_irq_dist_test.sv
`timescale 1ns/1ps
module edge_irq_dist_test;
    localparam int N  = 3;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_in = 1'b0;
    logic [N-1:0]      reg_wr = '0;
    logic [2*N-1:0]    reg_addr = '0;
    logic [DW*N-1:0]   reg_wdata = '0;
    logic [DW*N-1:0]   reg_rdata;
    logic [N-1:0]      irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    edge_irq_dist #(.N_CPU(N), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input int cpu, input logic [1:0] off, input logic [31:0] val);
        @(negedge clk);
        reg_wr[cpu] = 1'b1;
        reg_addr[cpu*2 +: 2] = off;
        reg_wdata[cpu*DW +: DW] = val;
        @(negedge clk);
        reg_wr[cpu] = 1'b0;
    endtask

    task automatic rd_reg(input int cpu, input logic [1:0] off, output logic [31:0] val);
        @(negedge clk);
        reg_addr[cpu*2 +: 2] = off;
        #1 val = reg_rdata[cpu*DW +: DW];
    endtask

    task automatic pulse();
        @(negedge clk);
        line_in = 1'b1;
        clocks(5);
        line_in = 1'b0;
        clocks(5);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {29'd0, irq}, 32'd0);
        for (int c = 0; c < N; c++)
            for (int o = 1; o < 4; o++) begin
                rd_reg(c, o[1:0], v);
                check("R1 regs", v, 32'd0);
            end
    endtask

    task automatic t_partial_ack();
        logic [31:0] v;
        for (int c = 0; c < N; c++) wr_reg(c, 2'd1, 32'd1);
        rd_reg(1, 2'd1, v);
        check("R3 enable readback", v, 32'd1);
        @(negedge clk);
        line_in = 1'b1;
        clocks(2);
        check("R2 not before third edge", {29'd0, irq}, 32'd0);
        clocks(1);
        check("R2 irq after three edges", {29'd0, irq}, 32'd7);
        line_in = 1'b0;
        clocks(4);
        wr_reg(0, 2'd2, 32'hDEAD);
        check("R4 only own cleared", {29'd0, irq}, 32'd6);
        pulse();
        check("R5 no recapture while pending", {29'd0, irq}, 32'd6);
        for (int c = 0; c < N; c++) begin
            rd_reg(c, 2'd3, v);
            check("R6 overrun set", v, 32'd1);
        end
        rd_reg(2, 2'd2, v);
        check("R6 capture unchanged", v, 32'd1);
        wr_reg(0, 2'd3, 32'd0);
        rd_reg(0, 2'd3, v);
        check("R7 write 0 ignored", v, 32'd1);
        wr_reg(0, 2'd3, 32'd1);
        rd_reg(0, 2'd3, v);
        check("R7 own overrun cleared", v, 32'd0);
        rd_reg(1, 2'd3, v);
        check("R7 other overrun kept", v, 32'd1);
        wr_reg(1, 2'd3, 32'd1);
        wr_reg(2, 2'd3, 32'd1);
        wr_reg(1, 2'd2, 32'd0);
        wr_reg(2, 2'd2, 32'd0);
        clocks(2);
        check("R4 all cleared", {29'd0, irq}, 32'd0);
        pulse();
        check("R5 rearmed after all acked", {29'd0, irq}, 32'd7);
        for (int c = 0; c < N; c++) wr_reg(c, 2'd2, 32'd0);
        clocks(2);
    endtask

    task automatic t_disabled_port();
        logic [31:0] v;
        wr_reg(1, 2'd1, 32'd0);
        pulse();
        check("R3 disabled port quiet", {29'd0, irq}, 32'd5);
        rd_reg(1, 2'd2, v);
        check("R3 disabled port captured", v, 32'd1);
        wr_reg(0, 2'd2, 32'd0);
        wr_reg(2, 2'd2, 32'd0);
        clocks(2);
        pulse();
        check("R5 disabled port does not block", {29'd0, irq}, 32'd5);
        rd_reg(0, 2'd3, v);
        check("R5 no overrun after rearm", v, 32'd0);
        for (int c = 0; c < N; c++) wr_reg(c, 2'd2, 32'd0);
        wr_reg(1, 2'd1, 32'd1);
        clocks(2);
    endtask

    task automatic t_level_and_fall();
        logic [31:0] v;
        @(negedge clk);
        line_in = 1'b1;
        clocks(5);
        rd_reg(2, 2'd0, v);
        check("R8 level high", v, 32'd1);
        for (int c = 0; c < N; c++) wr_reg(c, 2'd2, 32'd0);
        clocks(3);
        check("R2 steady high no capture", {29'd0, irq}, 32'd0);
        line_in = 1'b0;
        clocks(6);
        check("R2 falling edge no capture", {29'd0, irq}, 32'd0);
        rd_reg(0, 2'd0, v);
        check("R8 level low", v, 32'd0);
    endtask

    initial begin : watchdog
        #1ms;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        clocks(3);
        rst_n = 1'b1;
        clocks(2);
        t_reset();
        t_partial_ack();
        t_disabled_port();
        t_level_and_fall();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule